// File: doc/BRIEF.md
# Banked GPIO Register Port

A register-mapped general-purpose I/O port of up to 24 lines, grouped in 8-bit banks and reached over a byte-wide read/write bus. Software chooses a direction per line and moves the output latch through separate write-one-to-set and write-one-to-clear registers. A monitor register returns the live pin level. Each line can flag rising and/or falling edges. A detected edge lands in a status register and in an edge-detect register. The status bits, masked by a per-line enable, drive one active-high interrupt. Both registers are cleared by writing ones back.

Line n lives in bank n/8 at bit n%8. Every register group occupies three consecutive addresses with the most significant bank at the lowest address. Group bases are: monitor 0x00, direction 0x03, set 0x06, clear 0x09, rising enable 0x0C, falling enable 0x0F, interrupt enable 0x12, status 0x15, edge-detect 0x18. Pin inputs arrive already synchronised.

Bus reads go through a two-state access machine. `ACC_IDLE` moves to `ACC_RESP` when a read is requested. `ACC_RESP` stays in `ACC_RESP` on a back-to-back read and returns to `ACC_IDLE` otherwise. Read data is registered and valid while in `ACC_RESP`. Writes take effect on the clock edge at which they are presented, in either state.

Top module: `pinport_regs`

## Requirements
- R1: After reset every line is an input (pin_oe 0), the output latch is 0, all enables, status and edge-detect bits are 0, irq is low and bus_rvalid is low.
- R2: A direction bit of 1 makes the line an output (pin_oe bit 1); 0 makes it an input. Direction reads back as written.
- R3: Writing a 1 to a bit of the set group drives that pin_out bit high. Writing a 1 to a bit of the clear group drives it low. Zero bits in either write leave pin_out unchanged. pin_out changes only on a write.
- R4: The monitor group returns pin_in for every line, whatever its direction.
- R5: With the rising enable bit set, a 0-to-1 change of pin_in sets the line's status and edge-detect bits. The change shows at the first clock edge after pin_in changes.
- R6: With the falling enable bit set, a 1-to-0 change of pin_in sets the line's status and edge-detect bits. With the bit clear, a falling change has no effect.
- R7: With both enables set, either change sets the bits. With neither set, no change sets them.
- R8: irq is high exactly when some status bit has its interrupt-enable bit set. Clearing the enable drops irq while leaving the status bit intact.
- R9: Writing 1s to the status or edge-detect group clears those bits, and each group clears independently. An edge arriving in the same cycle as the clearing write leaves the bit set.
- R10: Within every group, address base+0 holds bank 2 (lines 23..16), base+1 bank 1, base+2 bank 0.
- R11: Unmapped addresses (0x1B and up) and the write-only set and clear groups read 0x00. Writes to the monitor group or to unmapped addresses change nothing.
- R12: A read presented at one clock edge gives bus_rvalid high with its data after that edge. bus_rvalid is low after an edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | Read data valid (state ACC_RESP) |
| pin_in | input | 24 | Synchronised pin levels |
| pin_out | output | 24 | Output latch |
| pin_oe | output | 24 | Output enable per line (direction) |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench feeds pin_in through a pad model that mixes the output latch with an external level. This exposes a monitor that reads the latch instead of the pin, or ignores output lines. Edge tests check that irq is still low immediately after the pin moves and high one clock later, so extra pipelining or a missing previous-sample register is caught. A clearing write and a fresh edge are presented in the same cycle; a design that lets the clear win loses the interrupt. Status is read from the most significant bank's address, and status and edge-detect are cleared separately, so a reversed bank order or shared clear logic shows up as wrong read data.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
    localparam int BANK_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int MAX_BANKS = 3;

    localparam logic [ADDR_W-1:0] A_MON  = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIR  = 8'h03;
    localparam logic [ADDR_W-1:0] A_SET  = 8'h06;
    localparam logic [ADDR_W-1:0] A_CLR  = 8'h09;
    localparam logic [ADDR_W-1:0] A_RISE = 8'h0C;
    localparam logic [ADDR_W-1:0] A_FALL = 8'h0F;
    localparam logic [ADDR_W-1:0] A_IEN  = 8'h12;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h15;
    localparam logic [ADDR_W-1:0] A_EDGE = 8'h18;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    // most significant bank sits at the group base
    function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base, input int b);
        return base + ADDR_W'(MAX_BANKS - 1 - b);
    endfunction
endpackage

// File: rtl/pinport_edge.sv
module pinport_edge #(
    parameter int NL = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] pin,
    input  logic [NL-1:0] rise_en,
    input  logic [NL-1:0] fall_en,
    output logic [NL-1:0] evt
);
    logic [NL-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin;
    end

    for (genvar i = 0; i < NL; i++) begin : g_line
        assign evt[i] = (rise_en[i] &  pin[i] & ~prev_q[i])
                      | (fall_en[i] & ~pin[i] &  prev_q[i]);
    end
endmodule

// File: rtl/pinport_rdmux.sv
module pinport_rdmux import pinport_pkg::*; #(
    parameter  int NUM_BANKS = 3,
    localparam int NL        = NUM_BANKS * BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NL-1:0]     mon,
    input  logic [NL-1:0]     dir,
    input  logic [NL-1:0]     rise,
    input  logic [NL-1:0]     fall,
    input  logic [NL-1:0]     ien,
    input  logic [NL-1:0]     stat,
    input  logic [NL-1:0]     edg,
    output logic [BANK_W-1:0] rd
);
    always_comb begin
        rd = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == bank_addr(A_MON,  b)) rd = mon[b*BANK_W +: BANK_W];
            if (addr == bank_addr(A_DIR,  b)) rd = dir[b*BANK_W +: BANK_W];
            if (addr == bank_addr(A_RISE, b)) rd = rise[b*BANK_W +: BANK_W];
            if (addr == bank_addr(A_FALL, b)) rd = fall[b*BANK_W +: BANK_W];
            if (addr == bank_addr(A_IEN,  b)) rd = ien[b*BANK_W +: BANK_W];
            if (addr == bank_addr(A_STAT, b)) rd = stat[b*BANK_W +: BANK_W];
            if (addr == bank_addr(A_EDGE, b)) rd = edg[b*BANK_W +: BANK_W];
        end
    end
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs import pinport_pkg::*; #(
    parameter  int NUM_BANKS = 3,
    localparam int NL        = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NL-1:0]     pin_in,
    output logic [NL-1:0]     pin_out,
    output logic [NL-1:0]     pin_oe,
    output logic              irq
);
    logic wr_req, rd_req;
    assign wr_req = bus_sel &  bus_we;
    assign rd_req = bus_sel & ~bus_we;

    logic [NL-1:0] dir_q, out_q, rise_q, fall_q, ien_q, stat_q, edge_q, evt;
    logic [NL-1:0] m_dir, m_set, m_clr, m_rise, m_fall, m_ien, m_stat, m_edge;
    logic [NL-1:0] wd_all;
    assign wd_all = {NUM_BANKS{bus_wdata}};

    // per-bank write strobes spread across the bank's lines
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        assign m_dir [LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_DIR,  b)}};
        assign m_set [LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_SET,  b)}};
        assign m_clr [LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_CLR,  b)}};
        assign m_rise[LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_RISE, b)}};
        assign m_fall[LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_FALL, b)}};
        assign m_ien [LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_IEN,  b)}};
        assign m_stat[LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_STAT, b)}};
        assign m_edge[LO +: BANK_W] = {BANK_W{wr_req && bus_addr == bank_addr(A_EDGE, b)}};
    end

    pinport_edge #(.NL(NL)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pin_in),
        .rise_en (rise_q),
        .fall_en (fall_q),
        .evt     (evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            ien_q  <= '0;
            stat_q <= '0;
            edge_q <= '0;
        end else begin
            dir_q  <= (dir_q  & ~m_dir)  | (wd_all & m_dir);
            rise_q <= (rise_q & ~m_rise) | (wd_all & m_rise);
            fall_q <= (fall_q & ~m_fall) | (wd_all & m_fall);
            ien_q  <= (ien_q  & ~m_ien)  | (wd_all & m_ien);
            out_q  <= (out_q | (wd_all & m_set)) & ~(wd_all & m_clr);
            // a new edge beats a clearing write in the same cycle
            stat_q <= (stat_q & ~(wd_all & m_stat)) | evt;
            edge_q <= (edge_q & ~(wd_all & m_edge)) | evt;
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = |(stat_q & ien_q);

    logic [BANK_W-1:0] rd_byte;
    pinport_rdmux #(.NUM_BANKS(NUM_BANKS)) u_rdmux (
        .addr (bus_addr),
        .mon  (pin_in),
        .dir  (dir_q),
        .rise (rise_q),
        .fall (fall_q),
        .ien  (ien_q),
        .stat (stat_q),
        .edg  (edge_q),
        .rd   (rd_byte)
    );

    // access state machine
    acc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_req) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_req ? ACC_RESP : ACC_IDLE;
        endcase
    end

    logic [BANK_W-1:0] rdata_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_byte;
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == ACC_RESP);

    // ---------------- assertions ----------------
    p_resp_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    p_no_resp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(pin_out));

    p_oe_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && bus_addr == bank_addr(A_DIR, 0)) |=> pin_oe[BANK_W-1:0] == $past(bus_wdata));

    p_evt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)) && ((edge_q & $past(evt)) == $past(evt)));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt) || $past(wr_req)));
endmodule

// File: tb/test_pinport_regs.sv
module test_pinport_regs;
    localparam int NL = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          bus_rvalid;
    logic [NL-1:0] pin_out, pin_oe;
    logic [NL-1:0] ext = '0;
    logic [NL-1:0] pin;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // pad model: driven lines show the latch, others the external level
    assign pin = (pin_oe & pin_out) | (~pin_oe & ext);

    pinport_regs i_pinport_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pin_in     (pin),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .irq        (irq)
    );

    function automatic logic [7:0] ad(input logic [7:0] base, input int bank);
        return base + 8'(2 - bank);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        chk("R12 rvalid after read", 32'(bus_rvalid), 1);
        d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, 32'(d), 32'(exp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 pin_out", pin_out, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rvalid", 32'(bus_rvalid), 0);
        rdchk("R1 dir bank0", ad(8'h03, 0), 8'h00);
        rdchk("R1 status bank2", ad(8'h15, 2), 8'h00);
        idle(1);
        chk("R12 rvalid low when idle", 32'(bus_rvalid), 0);
    endtask

    task automatic t_direction();
        wr(ad(8'h03, 0), 8'h3C);
        chk("R2 oe bank0", pin_oe, 24'h00003C);
        wr(8'h03, 8'h81);
        chk("R10 dir base addr is bank2", pin_oe, 24'h81003C);
        rdchk("R2 dir readback", 8'h03, 8'h81);
    endtask

    task automatic t_set_clear();
        wr(ad(8'h06, 0), 8'h0F);
        chk("R3 set", pin_out, 24'h00000F);
        wr(ad(8'h09, 0), 8'h03);
        chk("R3 clear", pin_out, 24'h00000C);
        wr(ad(8'h06, 0), 8'h00);
        chk("R3 set zeros no effect", pin_out, 24'h00000C);
        wr(ad(8'h09, 0), 8'h00);
        chk("R3 clear zeros no effect", pin_out, 24'h00000C);
        rdchk("R11 set group reads 0", ad(8'h06, 0), 8'h00);
        rdchk("R11 clear group reads 0", ad(8'h09, 0), 8'h00);
    endtask

    task automatic t_monitor();
        ext[7:0] = 8'hC3;
        rdchk("R4 monitor mixed dir", ad(8'h00, 0), 8'hCF);
        ext[7:0] = 8'hFF;
        rdchk("R4 monitor outputs keep latch", ad(8'h00, 0), 8'hCF);
        wr(ad(8'h03, 0), 8'h00);
        ext[7:0] = 8'h00;
        rdchk("R4 monitor all inputs", ad(8'h00, 0), 8'h00);
    endtask

    task automatic t_rise();
        wr(ad(8'h0C, 1), 8'h01);
        wr(ad(8'h12, 1), 8'hFF);
        @(negedge clk);
        ext[8] = 1'b1;
        #1 chk("R5 no irq before edge", 32'(irq), 0);
        @(negedge clk);
        chk("R5 irq one edge later", 32'(irq), 1);
        rdchk("R5 status", ad(8'h15, 1), 8'h01);
        rdchk("R5 edge-detect", ad(8'h18, 1), 8'h01);
        ext[8] = 1'b0;
        idle(2);
        wr(ad(8'h15, 1), 8'h01);
        wr(ad(8'h18, 1), 8'h01);
        chk("R9 cleared irq", 32'(irq), 0);
        rdchk("R6 falling without enable ignored", ad(8'h15, 1), 8'h00);
    endtask

    task automatic t_fall();
        wr(ad(8'h0F, 1), 8'h02);
        ext[9] = 1'b1;
        idle(2);
        chk("R6 rising ignored on fall-only", 32'(irq), 0);
        @(negedge clk);
        ext[9] = 1'b0;
        @(negedge clk);
        chk("R6 falling raises irq", 32'(irq), 1);
        rdchk("R6 status", ad(8'h15, 1), 8'h02);
        wr(ad(8'h15, 1), 8'h02);
        wr(ad(8'h18, 1), 8'h02);
    endtask

    task automatic t_both();
        wr(ad(8'h0C, 1), 8'h04);
        wr(ad(8'h0F, 1), 8'h04);
        ext[10] = 1'b1;
        idle(2);
        rdchk("R7 both: rise", ad(8'h15, 1), 8'h04);
        wr(ad(8'h15, 1), 8'h04);
        ext[10] = 1'b0;
        idle(2);
        rdchk("R7 both: fall", ad(8'h15, 1), 8'h04);
        wr(ad(8'h15, 1), 8'h04);
        wr(ad(8'h18, 1), 8'h04);
        ext[11] = 1'b1;
        idle(2);
        ext[11] = 1'b0;
        idle(2);
        rdchk("R7 no enables no status", ad(8'h15, 1), 8'h00);
        chk("R7 no irq", 32'(irq), 0);
    endtask

    task automatic t_mask();
        wr(ad(8'h12, 1), 8'h00);
        ext[10] = 1'b1;
        idle(2);
        chk("R8 masked no irq", 32'(irq), 0);
        rdchk("R8 status kept when masked", ad(8'h15, 1), 8'h04);
        wr(ad(8'h12, 1), 8'h04);
        chk("R8 unmask raises irq", 32'(irq), 1);
        wr(ad(8'h15, 1), 8'h04);
        wr(ad(8'h18, 1), 8'h04);
        chk("R8 irq low after clear", 32'(irq), 0);
    endtask

    task automatic t_simul();
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ad(8'h15, 1); bus_wdata = 8'h04;
        ext[10] = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        chk("R9 edge beats clear", 32'(irq), 1);
        rdchk("R9 status kept", ad(8'h15, 1), 8'h04);
        wr(ad(8'h15, 1), 8'h04);
        chk("R9 clear drops irq", 32'(irq), 0);
        rdchk("R9 edge-detect independent", ad(8'h18, 1), 8'h04);
        wr(ad(8'h18, 1), 8'h04);
        rdchk("R9 edge-detect cleared", ad(8'h18, 1), 8'h00);
    endtask

    task automatic t_order();
        wr(8'h0C, 8'h02);
        wr(8'h12, 8'h02);
        ext[17] = 1'b1;
        idle(2);
        chk("R10 irq from bank2", 32'(irq), 1);
        rdchk("R10 status base is bank2", 8'h15, 8'h02);
        rdchk("R10 status base+2 is bank0", 8'h17, 8'h00);
        wr(8'h15, 8'h02);
        wr(8'h18, 8'h02);
        chk("R10 cleared", 32'(irq), 0);
    endtask

    task automatic t_unmapped();
        logic [NL-1:0] oe0, out0;
        oe0 = pin_oe; out0 = pin_out;
        rdchk("R11 unmapped 0x40", 8'h40, 8'h00);
        rdchk("R11 unmapped 0x1B", 8'h1B, 8'h00);
        wr(8'h00, 8'hFF);
        wr(8'h40, 8'hFF);
        wr(8'h1B, 8'hFF);
        chk("R11 oe unchanged", pin_oe, oe0);
        chk("R11 out unchanged", pin_out, out0);
        chk("R11 irq unchanged", 32'(irq), 0);
        rdchk("R11 monitor still live", 8'h00, 8'h02);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_direction();
        t_set_clear();
        t_monitor();
        t_rise();
        t_fall();
        t_both();
        t_mask();
        t_simul();
        t_order();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule